// File: doc/BRIEF.md
# Change-of-State Input Interrupt Controller

This unit samples 32 digital input lines and makes their current levels readable over a small 32-bit register bus. The lower 16 lines can also raise an interrupt when their state changes. Two selection masks pick which lines take part and which polarity each line watches for. A control register chooses how the selected lines are combined and gates the interrupt output.

There are two combining modes. In edge mode (OR), any selected line that shows its chosen transition raises the interrupt. In level mode (AND), the interrupt is raised once every selected line sits at its chosen level at the same time. After that the unit stays quiet until a selected line changes level. When the event is taken, the unit stores the state of the 16 interruptible lines. Software reads that snapshot from the status register, and the read clears the pending event.

Top module: `cos_irq_unit`

## Requirements
- R1: After a synchronous active-low reset, `irq_o` is low and the rising mask, falling mask, control and status registers all read zero.
- R2: A read at byte address 0x00 returns all 32 input lines after a two-flop synchronizer. A level driven on `pins_i` becomes visible there two rising clock edges later.
- R3: The rising/high mask sits at 0x04 and the falling/low mask at 0x08. Both hold and read back a full 32-bit word. Status is at 0x0C, with the snapshot in bits 15:0 and zeros above. Control is at 0x10, with bit 1 as the mode (0 = OR/edge, 1 = AND/level) and bit 2 as the enable. A control read returns only bits 1 and 2.
- R4: In OR mode, a rising-mask bit makes its line fire on a 0-to-1 change and a falling-mask bit makes it fire on a 1-to-0 change. A line with both bits set fires on either change. A change in the opposite direction does nothing.
- R5: In AND mode, a line with its rising-mask bit set is satisfied when high, and a line with its falling-mask bit set is satisfied when low. A line with both bits set is always satisfied. The unit fires when all selected lines are satisfied together, and lines with neither bit set are ignored.
- R6: After an AND-mode firing, the unit does not fire again until a selected line changes level or the control register is written.
- R7: Only lines 0 to 15 take part in interrupts. If no mask bit is set among them, no interrupt occurs in either mode.
- R8: A read at 0x0C returns the line 15..0 levels captured when the event was taken, and it clears the pending event. While an event is pending, later events do not overwrite the snapshot.
- R9: While the enable bit is clear, events are not recorded. Writing the control register leaves both masks unchanged.
- R10: `irq_o` is an active-high level. It is high exactly while an event is pending and the enable bit is set, so it drops when the enable bit is cleared and returns when it is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | 32 | Asynchronous digital input lines |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe; data is valid in the same cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is active |
| irq_o | output | 1 | Interrupt request, active-high level |

## Verification
The bench tests the wrong-polarity edge in OR mode. A detector that treats any toggle as an event would raise `irq_o` there. It also tests lines with both mask bits set, which must fire on either edge in OR mode and count as satisfied in AND mode. Lines above 15 and all-zero masks are driven hard to catch a design that leaks those bits into the combiner. For level mode, the bench holds the condition after a read and expects silence. It then drops and restores a line and expects a second interrupt, so a unit that never disarms fires twice and a unit that never rearms stays dead. Further checks cover a second event arriving while one is pending (the snapshot must keep the first) and an edge seen while disabled (it must not appear once enabled).

// File: rtl/cos_pkg.sv
// Shared constants and types for the change-of-state interrupt unit.
// Assumes byte addressing on a word-aligned register bus.
package cos_pkg;

    // register byte offsets
    localparam int unsigned OFS_DATA  = 32'h00;
    localparam int unsigned OFS_RMASK = 32'h04;
    localparam int unsigned OFS_FMASK = 32'h08;
    localparam int unsigned OFS_STAT  = 32'h0C;
    localparam int unsigned OFS_CTRL  = 32'h10;

    // control register bit positions
    localparam int unsigned CTRL_MODE_BIT = 1;
    localparam int unsigned CTRL_EN_BIT   = 2;

    typedef enum logic {
        COMB_OR  = 1'b0,
        COMB_AND = 1'b1
    } comb_mode_t;

endpackage

// File: rtl/cos_sync.sv
// Two-flop synchronizer for a bus of asynchronous input lines.
// Assumes each line is quasi-static relative to clk; no bus coherency is implied.
module cos_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stable_q;

    // two register stages per line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_i;
            stable_q <= meta_q;
        end
    end

    assign sync_o = stable_q;

endmodule

// File: rtl/cos_detect.sv
// Per-line edge and level qualification and the OR/AND combiner.
// Assumes lvl_i is already synchronized. It keeps a one-cycle history for edge
// detection and an arming flag that holds off repeated level-mode firings.
module cos_detect
    import cos_pkg::*;
#(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    input  logic [N-1:0] rmask_i,
    input  logic [N-1:0] fmask_i,
    input  comb_mode_t   mode_i,
    input  logic         en_i,
    input  logic         rearm_i,
    output logic         fire_o
);

    logic [N-1:0] prev_q;
    logic [N-1:0] rise_hit;
    logic [N-1:0] fall_hit;
    logic [N-1:0] sat;
    logic [N-1:0] sel;
    logic         armed_q;
    logic         or_hit;
    logic         and_hit;
    logic         sel_change;

    // one-cycle history of the synchronized levels
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    // per-line edge and level qualification
    for (genvar i = 0; i < N; i++) begin : g_line
        assign sel[i]      = rmask_i[i] | fmask_i[i];
        assign rise_hit[i] = rmask_i[i] &  lvl_i[i] & ~prev_q[i];
        assign fall_hit[i] = fmask_i[i] & ~lvl_i[i] &  prev_q[i];
        assign sat[i]      = ~sel[i]
                           | (rmask_i[i] & fmask_i[i])
                           | (rmask_i[i] &  lvl_i[i])
                           | (fmask_i[i] & ~lvl_i[i]);
    end

    // combine the lines for each mode
    always_comb begin
        or_hit     = |(rise_hit | fall_hit);
        sel_change = |((lvl_i ^ prev_q) & sel);
        and_hit    = (|sel) & (&sat) & armed_q;
        fire_o     = en_i & ((mode_i == COMB_AND) ? and_hit : or_hit);
    end

    // level-mode arming: cleared by a firing, set by a selected change or a control write
    always_ff @(posedge clk) begin
        if (!rst_n)                              armed_q <= 1'b1;
        else if (fire_o && mode_i == COMB_AND)   armed_q <= 1'b0;
        else if (sel_change || rearm_i)          armed_q <= 1'b1;
    end

    // R7: with no line selected nothing can fire
    assert_no_sel_no_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (~|(rmask_i | fmask_i)) |-> !fire_o);

    // R4: an OR-mode firing needs a level change on some line
    assert_or_needs_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o && mode_i == COMB_OR) |-> (|(lvl_i ^ prev_q)));

    // R6: a level-mode firing is never followed by another in the next cycle
    assert_no_refire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o && mode_i == COMB_AND) |=> !fire_o);

endmodule

// File: rtl/cos_irq_unit.sv
// Register-mapped change-of-state input unit: live data, two selection masks,
// status snapshot with clear-on-read, and a control register for mode and enable.
// Assumes single-cycle bus strobes; read data is combinational in the strobe cycle.
module cos_irq_unit
    import cos_pkg::*;
#(
    parameter int unsigned N_IN  = 32,
    parameter int unsigned N_IRQ = 16,
    parameter int unsigned DW    = 32,
    parameter int unsigned AW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N_IN-1:0] pins_i,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_o
);

    logic [N_IN-1:0]  sync_lvl;
    logic [DW-1:0]    rmask_q;
    logic [DW-1:0]    fmask_q;
    comb_mode_t       mode_q;
    logic             en_q;
    logic             pending_q;
    logic [N_IRQ-1:0] snap_q;
    logic             fire;
    logic             ctrl_wr;
    logic             stat_rd;

    assign ctrl_wr = bus_wr && (bus_addr == AW'(OFS_CTRL));
    assign stat_rd = bus_rd && (bus_addr == AW'(OFS_STAT));

    cos_sync #(.W(N_IN)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins_i),
        .sync_o  (sync_lvl)
    );

    cos_detect #(.N(N_IRQ)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_i   (sync_lvl[N_IRQ-1:0]),
        .rmask_i (rmask_q[N_IRQ-1:0]),
        .fmask_i (fmask_q[N_IRQ-1:0]),
        .mode_i  (mode_q),
        .en_i    (en_q),
        .rearm_i (ctrl_wr),
        .fire_o  (fire)
    );

    // configuration register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rmask_q <= '0;
            fmask_q <= '0;
            mode_q  <= COMB_OR;
            en_q    <= 1'b0;
        end else if (bus_wr) begin
            if (bus_addr == AW'(OFS_RMASK)) rmask_q <= bus_wdata;
            if (bus_addr == AW'(OFS_FMASK)) fmask_q <= bus_wdata;
            if (ctrl_wr) begin
                mode_q <= comb_mode_t'(bus_wdata[CTRL_MODE_BIT]);
                en_q   <= bus_wdata[CTRL_EN_BIT];
            end
        end
    end

    // pending flag: a new event wins over a clearing read in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)       pending_q <= 1'b0;
        else if (fire)    pending_q <= 1'b1;
        else if (stat_rd) pending_q <= 1'b0;
    end

    // snapshot of the interruptible lines, kept until the pending event is read
    always_ff @(posedge clk) begin
        if (!rst_n)                          snap_q <= '0;
        else if (fire && (!pending_q || stat_rd)) snap_q <= sync_lvl[N_IRQ-1:0];
    end

    // combinational read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                AW'(OFS_DATA):  bus_rdata = DW'(sync_lvl);
                AW'(OFS_RMASK): bus_rdata = rmask_q;
                AW'(OFS_FMASK): bus_rdata = fmask_q;
                AW'(OFS_STAT):  bus_rdata = DW'(snap_q);
                AW'(OFS_CTRL): begin
                    bus_rdata[CTRL_MODE_BIT] = mode_q;
                    bus_rdata[CTRL_EN_BIT]   = en_q;
                end
                default:        bus_rdata = '0;
            endcase
        end
    end

    assign irq_o = pending_q & en_q;

    // R8: a status read with no simultaneous event leaves the request low
    assert_clear_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !fire) |=> !irq_o);

    // R8: the snapshot taken with a new event equals the lines seen at that event
    assert_snap_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending_q) |-> (snap_q == $past(sync_lvl[N_IRQ-1:0])));

    // R9: a control write leaves both masks untouched
    assert_masks_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> ($stable(rmask_q) && $stable(fmask_q)));

endmodule

// File: tb/cos_irq_unit_bench.sv
`timescale 1ns/1ps
module cos_irq_unit_bench;

    localparam logic [4:0]  A_DATA = 5'h00;
    localparam logic [4:0]  A_RM   = 5'h04;
    localparam logic [4:0]  A_FM   = 5'h08;
    localparam logic [4:0]  A_STAT = 5'h0C;
    localparam logic [4:0]  A_CTRL = 5'h10;
    localparam logic [31:0] C_EN   = 32'h4;
    localparam logic [31:0] C_AND  = 32'h2;

    typedef struct packed {
        logic        and_m;
        logic [31:0] rm;
        logic [31:0] fm;
        logic [31:0] pin0;
        logic [31:0] pin1;
        logic        exp_irq;
        logic [15:0] exp_cap;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h0001, 32'h0000, 32'h0000_0000, 32'h0000_0001, 1'b1, 16'h0001}, // R4 rising
        '{1'b0, 32'h0000, 32'h0002, 32'h0000_0002, 32'h0000_0000, 1'b1, 16'h0000}, // R4 falling
        '{1'b0, 32'h0001, 32'h0000, 32'h0000_0001, 32'h0000_0000, 1'b0, 16'h0000}, // R4 wrong edge
        '{1'b0, 32'h0004, 32'h0004, 32'h0000_0004, 32'h0000_0000, 1'b1, 16'h0000}, // R4 both bits
        '{1'b0, 32'h0000, 32'h0000, 32'h0000_0000, 32'h0000_FFFF, 1'b0, 16'h0000}, // R7 no masks
        '{1'b0, 32'hFFFF_0000, 32'h0000, 32'h0000_0000, 32'hFFFF_0000, 1'b0, 16'h0000}, // R7 upper lines
        '{1'b1, 32'h0003, 32'h0004, 32'h0000_0000, 32'h0000_0003, 1'b1, 16'h0003}, // R5 all met
        '{1'b1, 32'h0003, 32'h0000, 32'h0000_0000, 32'h0000_0001, 1'b0, 16'h0000}, // R5 one missing
        '{1'b1, 32'h0009, 32'h0008, 32'h0000_0000, 32'h0000_0001, 1'b1, 16'h0001}, // R5 both bits satisfied
        '{1'b1, 32'h0000, 32'h0000, 32'h0000_0000, 32'h0000_FFFF, 1'b0, 16'h0000}, // R7 AND no masks
        '{1'b1, 32'h8000, 32'h0000, 32'h0000_0000, 32'hFFFF_8000, 1'b1, 16'h8000}  // R5 line 15, upper ignored
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins_i = '0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    cos_irq_unit u_cos_irq_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins_i    (pins_i),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        // R1: reset state
        idle(3);
        chk("R1 irq in reset", {31'b0, irq_o}, 32'h0);
        rst_n = 1'b1;
        idle(1);
        rd(A_RM, d);   chk("R1 rmask", d, 32'h0);
        rd(A_FM, d);   chk("R1 fmask", d, 32'h0);
        rd(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
        rd(A_STAT, d); chk("R1 status", d, 32'h0);
        chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);

        // R2: live data with two-edge latency
        pins_i = 32'hA5A5_1234;
        rd(A_DATA, d); chk("R2 data one edge", d, 32'h0);
        rd(A_DATA, d); chk("R2 data synced", d, 32'hA5A5_1234);
        pins_i = 32'h0;

        // R3: register read-back
        wr(A_RM, 32'hFFFF_00F0); rd(A_RM, d); chk("R3 rmask readback", d, 32'hFFFF_00F0);
        wr(A_FM, 32'h1234_5678); rd(A_FM, d); chk("R3 fmask readback", d, 32'h1234_5678);
        wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, d); chk("R3 ctrl readback", d, 32'h6);
        wr(A_CTRL, 32'h0);

        // table walk over modes and mask patterns
        for (int i = 0; i < NV; i++) begin
            vec_t v = VECS[i];
            string tag = v.and_m ? "R5 vector" : "R4 vector";
            wr(A_CTRL, 32'h0);
            pins_i = v.pin0;
            idle(4);
            rd(A_STAT, d);
            wr(A_RM, v.rm);
            wr(A_FM, v.fm);
            wr(A_CTRL, C_EN | (v.and_m ? C_AND : 32'h0));
            idle(3);
            chk($sformatf("%s %0d quiet", tag, i), {31'b0, irq_o}, 32'h0);
            pins_i = v.pin1;
            idle(5);
            chk($sformatf("%s %0d irq", tag, i), {31'b0, irq_o}, {31'b0, v.exp_irq});
            if (v.exp_irq) begin
                rd(A_STAT, d);
                chk($sformatf("R8 vector %0d capture", i), d, {16'h0, v.exp_cap});
                idle(2);
                chk($sformatf("R8 vector %0d cleared", i), {31'b0, irq_o}, 32'h0);
            end
        end

        // R8: snapshot keeps the first event while pending
        wr(A_CTRL, 32'h0); pins_i = 32'h0; idle(4); rd(A_STAT, d);
        wr(A_RM, 32'h3); wr(A_FM, 32'h0); wr(A_CTRL, C_EN);
        pins_i = 32'h1; idle(5);
        pins_i = 32'h3; idle(5);
        rd(A_STAT, d); chk("R8 first event kept", d, 32'h1);
        idle(2); chk("R8 irq dropped", {31'b0, irq_o}, 32'h0);

        // R6: level mode disarm and rearm
        wr(A_CTRL, 32'h0); pins_i = 32'h0; idle(4); rd(A_STAT, d);
        wr(A_RM, 32'h1); wr(A_FM, 32'h0); wr(A_CTRL, C_EN | C_AND);
        pins_i = 32'h1; idle(5);
        chk("R6 first fire", {31'b0, irq_o}, 32'h1);
        rd(A_STAT, d); idle(6);
        chk("R6 no refire while held", {31'b0, irq_o}, 32'h0);
        pins_i = 32'h0; idle(5);
        chk("R6 quiet after drop", {31'b0, irq_o}, 32'h0);
        pins_i = 32'h1; idle(5);
        chk("R6 refire after change", {31'b0, irq_o}, 32'h1);
        rd(A_STAT, d); chk("R6 capture", d, 32'h1);

        // R9: events while disabled are not recorded
        wr(A_CTRL, 32'h0); pins_i = 32'h0; idle(4); rd(A_STAT, d);
        wr(A_RM, 32'h1);
        pins_i = 32'h1; idle(5);
        wr(A_CTRL, C_EN); idle(3);
        chk("R9 disabled edge lost", {31'b0, irq_o}, 32'h0);
        wr(A_CTRL, 32'h0); wr(A_CTRL, C_EN);
        rd(A_RM, d); chk("R9 mask kept over toggle", d, 32'h1);
        pins_i = 32'h0; idle(4);
        pins_i = 32'h1; idle(5);
        chk("R9 fires after toggle", {31'b0, irq_o}, 32'h1);

        // R10: enable gates the level without losing the pending event
        wr(A_CTRL, 32'h0); idle(1);
        chk("R10 irq low when disabled", {31'b0, irq_o}, 32'h0);
        wr(A_CTRL, C_EN); idle(1);
        chk("R10 irq returns", {31'b0, irq_o}, 32'h1);
        rd(A_STAT, d); chk("R10 capture", d, 32'h1);
        idle(2);
        chk("R10 irq cleared", {31'b0, irq_o}, 32'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule